// File: doc/BRIEF.md
# Keypad Interrupt Request Controller

This block produces the active-low interrupt request of a key-scan controller. Two conditions can raise it: the number of events waiting in the key-event queue reaching a programmed level, and a programmed number of debounce periods elapsing after the latest key event. When both are enabled, the line goes active on whichever condition occurs first. Once active, it stays active until it is cleared by one of two policies, chosen by a mode bit: the queue draining to empty, or a host read of the queue.

An 8-bit setting selects the behaviour. A setting of zero takes the pin away from interrupt use and turns it into a general-purpose open-drain output that follows a port data bit. The block drives one registered signal, `irq_low`. When it is 1 the pad is pulled low. When it is 0 the pad is released.

The controller is a three-state machine. ST_GPO means the pin is a plain output. ST_IDLE means interrupt mode with the line released. ST_ASSERT means interrupt mode with the line pulled low. The transitions are:
- ST_GPO to ST_IDLE (setting becomes non-zero, no trigger present)
- ST_GPO to ST_ASSERT (setting becomes non-zero with the fill level already met)
- ST_IDLE to ST_ASSERT (trigger)
- ST_ASSERT to ST_IDLE (clear with no trigger present)
- ST_IDLE or ST_ASSERT to ST_GPO (setting becomes zero)
- each state back to itself

Top module: `kpd_irq_ctrl`

## Requirements
- R1: An asynchronous active-low reset puts the block in ST_GPO with `irq_low` at 0 (released). It also disarms the period timer, so a debounce tick after the reset cannot raise the line.
- R2: With `irq_cfg` = 0x00, `irq_low` equals the inverse of `gpo_bit` sampled at the previous clock edge. A `gpo_bit` of 0 pulls the pin low, and a `gpo_bit` of 1 releases it.
- R3: With N = `irq_cfg[4:0]` non-zero, `irq_low` becomes 1 at the clock edge that samples the Nth `db_tick` after the most recent `key_evt`.
- R4: The period timer raises the line once per arming. Further `db_tick` pulses without a new `key_evt` do not raise it again.
- R5: Every `key_evt` reloads the period count to N. A `db_tick` in the same cycle as a `key_evt` is not counted.
- R6: With m = `irq_cfg[7:5]` non-zero, `irq_low` becomes 1 at the edge after `q_count` >= 2*m is seen. When `q_count` is below 2*m, the fill condition does not raise the line.
- R7: With both m and N non-zero, the line asserts on whichever condition is met first. Each condition can raise it again after a clear.
- R8: With `clr_on_read` = 0, an active line is released at the edge after `q_empty` = 1 is seen. `host_rd` has no effect in this mode.
- R9: With `clr_on_read` = 1, an active line is released at the edge after `host_rd` = 1 is seen. `q_empty` has no effect in this mode.
- R10: When a clear and a trigger (fill level met, or the timer expiring) fall in the same cycle, the trigger wins and the line stays asserted.
- R11: Writing `irq_cfg` to 0x00 while the line is asserted moves the block to ST_GPO at the next edge, and the pin then follows `gpo_bit`. Leaving ST_GPO goes to ST_IDLE (released) with the timer disarmed.
- R12: With N = 0, key events and debounce ticks never raise the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_cfg | input | 8 | Interrupt setting: [7:5] fill level m, [4:0] period count N, 0x00 selects the GPO use |
| q_count | input | 5 | Number of events currently held in the key queue |
| key_evt | input | 1 | One-cycle strobe: a key event entered the queue |
| db_tick | input | 1 | One-cycle strobe at the end of each debounce period |
| host_rd | input | 1 | One-cycle strobe: the host read the queue |
| q_empty | input | 1 | The queue is empty |
| clr_on_read | input | 1 | Clear policy: 0 clears on empty queue, 1 clears on host read |
| gpo_bit | input | 1 | Port data bit used when the pin is a general-purpose output |
| irq_low | output | 1 | 1 pulls the interrupt pad low, 0 releases it |

## Verification
The clear path and the trigger path can act in the same cycle. This happens when a host read arrives in the cycle where the period timer expires, or while the queue still holds at least 2*m events. The bench provokes the first case by placing the Nth `db_tick` in the same cycle as `host_rd` while the line is already held by the fill condition. It then checks that `irq_low` is still 1 after that edge and drops only after a later read with no trigger. A second coincidence, a `key_evt` in the same cycle as the tick that would have expired the count, is judged by confirming that the line rises only after N further ticks.

// File: rtl/kpd_irq_pkg.sv
package kpd_irq_pkg;

    typedef enum logic [1:0] {
        ST_GPO    = 2'd0,
        ST_IDLE   = 2'd1,
        ST_ASSERT = 2'd2
    } irq_state_e;

endpackage

// File: rtl/kpd_irq_timer.sv
// Period trigger: counts debounce ticks after the latest key event and
// pulses fire once when the programmed count is reached.
module kpd_irq_timer #(
    parameter int TIME_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [TIME_W-1:0] n_sel,
    input  logic              key_evt,
    input  logic              db_tick,
    output logic              fire
);

    logic [TIME_W-1:0] cnt_q;
    logic              armed_q;
    logic              active;

    assign active = enable && (n_sel != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (!active) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (key_evt) begin
            cnt_q   <= n_sel;
            armed_q <= 1'b1;
        end else if (db_tick && armed_q) begin
            if (cnt_q == TIME_W'(1)) begin
                armed_q <= 1'b0;
            end
            cnt_q <= cnt_q - TIME_W'(1);
        end
    end

    assign fire = active && armed_q && db_tick && !key_evt && (cnt_q == TIME_W'(1));

    // R4
    timer_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    // R5
    timer_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (key_evt && (n_sel > TIME_W'(1))) |=> !fire);

endmodule

// File: rtl/kpd_irq_fill.sv
// Fill trigger: compares the queue level with twice the programmed value.
module kpd_irq_fill #(
    parameter int CNT_W  = 5,
    parameter int FILL_W = 3
) (
    input  logic [CNT_W-1:0]  q_count,
    input  logic [FILL_W-1:0] m_sel,
    output logic              hit
);

    localparam int THR_W = FILL_W + 1;
    localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

    logic [THR_W-1:0] thr;
    logic [CMP_W-1:0] lvl_x;
    logic [CMP_W-1:0] thr_x;

    assign thr   = {m_sel, 1'b0};
    assign lvl_x = CMP_W'(q_count);
    assign thr_x = CMP_W'(thr);
    assign hit   = (m_sel != '0) && (lvl_x >= thr_x);

endmodule

// File: rtl/kpd_irq_ctrl.sv
module kpd_irq_ctrl
    import kpd_irq_pkg::*;
#(
    parameter int CNT_W  = 5,
    parameter int TIME_W = 5,
    parameter int FILL_W = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [TIME_W+FILL_W-1:0]   irq_cfg,
    input  logic [CNT_W-1:0]           q_count,
    input  logic                       key_evt,
    input  logic                       db_tick,
    input  logic                       host_rd,
    input  logic                       q_empty,
    input  logic                       clr_on_read,
    input  logic                       gpo_bit,
    output logic                       irq_low
);

    localparam int CFG_W = TIME_W + FILL_W;

    irq_state_e state_q;
    irq_state_e state_d;

    logic gpo_mode;
    logic fill_hit;
    logic tmr_fire;
    logic trig;
    logic clr_hit;

    assign gpo_mode = (irq_cfg == '0);

    kpd_irq_timer #(
        .TIME_W (TIME_W)
    ) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (!gpo_mode),
        .n_sel   (irq_cfg[TIME_W-1:0]),
        .key_evt (key_evt),
        .db_tick (db_tick),
        .fire    (tmr_fire)
    );

    kpd_irq_fill #(
        .CNT_W  (CNT_W),
        .FILL_W (FILL_W)
    ) i_fill (
        .q_count (q_count),
        .m_sel   (irq_cfg[CFG_W-1:TIME_W]),
        .hit     (fill_hit)
    );

    assign trig    = fill_hit || tmr_fire;
    assign clr_hit = clr_on_read ? host_rd : q_empty;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GPO: begin
                if (!gpo_mode) begin
                    state_d = trig ? ST_ASSERT : ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (gpo_mode) begin
                    state_d = ST_GPO;
                end else if (trig) begin
                    state_d = ST_ASSERT;
                end
            end
            ST_ASSERT: begin
                if (gpo_mode) begin
                    state_d = ST_GPO;
                end else if (trig) begin
                    state_d = ST_ASSERT;
                end else if (clr_hit) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_GPO;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_GPO;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register, decoded from the next state so the pad never glitches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_low <= 1'b0;
        end else if (state_d == ST_GPO) begin
            irq_low <= !gpo_bit;
        end else begin
            irq_low <= (state_d == ST_ASSERT);
        end
    end

    // R2
    gpo_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gpo_mode |=> (irq_low == !$past(gpo_bit)));

    // R6
    fill_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gpo_mode && fill_hit) |=> irq_low);

    // R3
    time_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gpo_mode && tmr_fire) |=> irq_low);

    // R9
    hold_until_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASSERT && !gpo_mode && clr_on_read && !host_rd) |=> irq_low);

    // R8
    empty_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ASSERT && !gpo_mode && !clr_on_read && q_empty && !trig)
            |=> !irq_low);

endmodule

// File: tb/test_kpd_irq_ctrl.sv
module test_kpd_irq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_cfg = 8'h00;
    logic [4:0] q_count = 5'd0;
    logic       key_evt = 1'b0;
    logic       db_tick = 1'b0;
    logic       host_rd = 1'b0;
    logic       q_empty = 1'b1;
    logic       clr_on_read = 1'b0;
    logic       gpo_bit = 1'b1;
    logic       irq_low;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    kpd_irq_ctrl i_kpd_irq_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_cfg     (irq_cfg),
        .q_count     (q_count),
        .key_evt     (key_evt),
        .db_tick     (db_tick),
        .host_rd     (host_rd),
        .q_empty     (q_empty),
        .clr_on_read (clr_on_read),
        .gpo_bit     (gpo_bit),
        .irq_low     (irq_low)
    );

    // Vector: [23:20] req, [19:12] cfg, [11:7] count, [6] key, [5] tick,
    //         [4] read, [3] empty, [2] clear mode, [1] gpo bit, [0] expected
    localparam int NV = 52;
    localparam logic [23:0] VEC [NV] = '{
        {4'd2,  8'h00, 5'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 1'b1}, // R2 gpo low
        {4'd2,  8'h00, 5'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 1'b0}, // R2 gpo release
        {4'd11, 8'h03, 5'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 1'b0}, // R11 leave gpo
        {4'd3,  8'h03, 5'd1, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0}, // R3 key, N=3
        {4'd3,  8'h03, 5'd1, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 1'b0},
        {4'd3,  8'h03, 5'd1, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b0},
        {4'd3,  8'h03, 5'd1, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 1'b0},
        {4'd3,  8'h03, 5'd1, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 1'b1}, // R3 third tick
        {4'd4,  8'h03, 5'd1, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 1'b1},
        {4'd8,  8'h03, 5'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 1'b0}, // R8 empty clears
        {4'd4,  8'h03, 5'd0, 1'b0,1'b1,1'b0,1'b1,1'b0,1'b1, 1'b0}, // R4 no re-fire
        {4'd6,  8'h40, 5'd3, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b0}, // R6 below 4
        {4'd6,  8'h40, 5'd4, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b1}, // R6 at 4
        {4'd9,  8'h40, 5'd3, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b1},
        {4'd9,  8'h40, 5'd0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 1'b1}, // R9 empty ignored
        {4'd9,  8'h40, 5'd0, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0}, // R9 read clears
        {4'd9,  8'h40, 5'd0, 1'b0,1'b0,1'b0,1'b1,1'b1,1'b1, 1'b0},
        {4'd6,  8'h40, 5'd5, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1},
        {4'd8,  8'h40, 5'd1, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 1'b1}, // R8 read ignored
        {4'd8,  8'h40, 5'd0, 1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 1'b0},
        {4'd7,  8'h62, 5'd1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b0}, // R7 both enabled
        {4'd7,  8'h62, 5'd1, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, 1'b0},
        {4'd7,  8'h62, 5'd1, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, 1'b1}, // R7 time first
        {4'd9,  8'h62, 5'd1, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0},
        {4'd7,  8'h62, 5'd6, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b1}, // R7 fill first
        {4'd9,  8'h62, 5'd2, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0},
        {4'd7,  8'h62, 5'd6, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b1},
        {4'd9,  8'h62, 5'd2, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, 1'b1},
        {4'd10, 8'h62, 5'd2, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 1'b1}, // R10 fire beats read
        {4'd9,  8'h62, 5'd2, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0},
        {4'd5,  8'h02, 5'd1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b0}, // R5 reload
        {4'd5,  8'h02, 5'd1, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, 1'b0},
        {4'd5,  8'h02, 5'd1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b0},
        {4'd5,  8'h02, 5'd1, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, 1'b0},
        {4'd5,  8'h02, 5'd1, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, 1'b1},
        {4'd9,  8'h02, 5'd0, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0},
        {4'd3,  8'h02, 5'd1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b0},
        {4'd3,  8'h02, 5'd1, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, 1'b0},
        {4'd3,  8'h02, 5'd1, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b1, 1'b1},
        {4'd11, 8'h00, 5'd1, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b0}, // R11 to gpo
        {4'd11, 8'h00, 5'd1, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1},
        {4'd11, 8'h02, 5'd1, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0}, // R11 back idle
        {4'd5,  8'h02, 5'd1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0},
        {4'd5,  8'h02, 5'd1, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0},
        {4'd5,  8'h02, 5'd1, 1'b1,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0}, // R5 key+tick
        {4'd5,  8'h02, 5'd1, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0},
        {4'd5,  8'h02, 5'd1, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b1},
        {4'd12, 8'h20, 5'd0, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0}, // R12 N=0
        {4'd12, 8'h20, 5'd1, 1'b1,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b0},
        {4'd12, 8'h20, 5'd1, 1'b0,1'b1,1'b0,1'b0,1'b1,1'b0, 1'b0},
        {4'd6,  8'h20, 5'd2, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1}, // R6 at 2
        {4'd9,  8'h20, 5'd0, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b0, 1'b0}
    };

    task automatic check(input int req, input logic exp, input string what);
        checks++;
        if (irq_low !== exp) begin
            errors++;
            $display("FAIL R%0d %s: irq_low=%0b expected %0b", req, what, irq_low, exp);
        end
    endtask

    task automatic drive(input logic [7:0] cfg, input logic [4:0] cnt,
                         input logic kev, input logic tk, input logic rd,
                         input logic emp, input logic clr, input logic gpo);
        @(negedge clk);
        irq_cfg     = cfg;
        q_count     = cnt;
        key_evt     = kev;
        db_tick     = tk;
        host_rd     = rd;
        q_empty     = emp;
        clr_on_read = clr;
        gpo_bit     = gpo;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(1, 1'b0, "during reset");                       // R1
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(1, 1'b0, "after reset release");                // R1

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][19:12], VEC[i][11:7], VEC[i][6], VEC[i][5],
                  VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
            check(int'(VEC[i][23:20]), VEC[i][0], $sformatf("vector %0d", i));
        end

        // R1: reset while the pin is pulled low in GPO use
        drive(8'h00, 5'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        check(2, 1'b1, "gpo low before reset");               // R2
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check(1, 1'b0, "asynchronous reset releases");        // R1

        // R1: a timer armed before reset stays disarmed after it
        @(negedge clk);
        irq_cfg = 8'h01;
        key_evt = 1'b1;
        q_empty = 1'b0;
        q_count = 5'd1;
        clr_on_read = 1'b1;
        @(negedge clk);
        key_evt = 1'b0;
        rst_n = 1'b1;
        drive(8'h01, 5'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        check(1, 1'b0, "tick after reset, timer disarmed");   // R1
        drive(8'h01, 5'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check(3, 1'b0, "key with N=1");                       // R3
        drive(8'h01, 5'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        check(3, 1'b1, "first tick with N=1");                // R3

        // R6: highest fill level 14 at m=7
        drive(8'hE0, 5'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        check(9, 1'b0, "read clears before fill test");       // R9
        drive(8'hE0, 5'd13, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check(6, 1'b0, "13 below 14");                        // R6
        drive(8'hE0, 5'd14, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        check(6, 1'b1, "14 reaches level");                   // R6
        drive(8'hE0, 5'd14, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        check(10, 1'b1, "read with level still met");         // R10

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule